// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the eight sticky status bits of a serial controller that runs either an I2C bus or a plain clock-synchronous shift link. The shift engine and the bus monitor send it single-cycle event pulses: start or stop seen, address or general-call match, SDA mismatch, missing acknowledge, bytes moving between shift and data registers, the ninth SCL clock, and the last bit of a frame. The block qualifies each pulse with the current mode and turns it into a flag. The flag vector is driven out continuously so it can serve as interrupt sources.

Software sees the flags through a status register port with a read strobe, a write strobe and write data. A flag can be cleared by writing 0 to its bit, but only after that bit was read as 1. The transmit-empty, transmit-done and receive-full flags also clear by themselves when the transmit data register is written or the receive data register is read. When a hardware set and a clear land in the same cycle, the set wins.

Top module: `i2c_stat_flags`

## Requirements
- R1: After a synchronous reset all eight flags are 0 and `st_rdata` is 0.
- R2: Bit positions are: 7 transmit empty, 6 transmit done, 5 receive full, 4 no-acknowledge, 3 stop, 2 lost/overrun, 1 address match, 0 general call. A status write with bit i at 0 clears flag i when flag i was returned as 1 by a status read since the last status write.
- R3: A status write never sets a flag. A 0 written without a prior read of 1 leaves the flag unchanged. Any status write consumes the read permission for all bits.
- R4: Transmit empty sets on a transmit-register-to-shift transfer, on a write of the transmit-mode bit to 1, on start generation, and on a slave receive to slave transmit change.
- R5: A write to the transmit data register (`txd_wr`) clears both transmit empty and transmit done.
- R6: In I2C format, transmit done sets on the ninth SCL clock only while transmit empty is 1. In synchronous format it sets on the last transmitted bit.
- R7: Receive full sets when a received byte moves into the receive data register and clears on a receive data register read (`rxd_rd`).
- R8: No-acknowledge sets on a missing acknowledge only while `ack_chk_en` is 1.
- R9: In I2C format, lost sets in master mode on an SDA mismatch while transmitting, or on a start detected while `sda_hi` is 1. In slave mode or in master receive, a mismatch has no effect.
- R10: In synchronous format, bit 2 is an overrun flag. It sets when a last received bit arrives while receive full is 1.
- R11: In slave receive mode, an address match sets bit 1 and a general call sets bit 0, only within the first frame after a start. The first frame ends at the ninth SCL clock.
- R12: A detected stop sets the stop flag only after a master-mode ninth SCL clock, an address match, or a general call since the previous stop.
- R13: A hardware set event has priority over a software or data-register clear in the same cycle.
- R14: `st_rdata` shows the flag vector as it was at the clock edge of a status read, one cycle after `st_rd`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sync | input | 1 | 1 = clock-synchronous format, 0 = I2C format |
| is_master | input | 1 | Controller is bus master |
| is_xmit | input | 1 | Controller is transmitting |
| ack_chk_en | input | 1 | Acknowledge check enable |
| sda_hi | input | 1 | SDA held high by this controller |
| ev_start_det | input | 1 | Start condition detected |
| ev_stop_det | input | 1 | Stop condition detected |
| ev_addr_match | input | 1 | First frame matched own slave address |
| ev_gcall | input | 1 | General-call address detected |
| ev_sda_mismatch | input | 1 | Driven and sampled SDA differ at SCL rise |
| ev_nack | input | 1 | No acknowledge from receiver |
| ev_tx_load | input | 1 | Byte moved from transmit data to shift register |
| ev_trs_set | input | 1 | Transmit-mode bit written to 1 |
| ev_start_gen | input | 1 | Start or repeated start generated |
| ev_slv_to_tx | input | 1 | Slave receive changed to slave transmit |
| ev_ninth_scl | input | 1 | Ninth SCL clock |
| ev_tx_last | input | 1 | Last bit of a synchronous frame shifted out |
| ev_rx_last | input | 1 | Last bit of a received byte shifted in |
| ev_rx_xfer | input | 1 | Byte moved from shift to receive data register |
| txd_wr | input | 1 | Transmit data register write |
| rxd_rd | input | 1 | Receive data register read |
| st_rd | input | 1 | Status register read strobe |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status register write data |
| st_rdata | output | 8 | Registered status read data |
| flags_o | output | 8 | Live flag vector / interrupt sources |

## Verification
The hardest case to reach is the stop flag, because it depends on hidden context: a qualifying frame since the previous stop. The bench runs a stop with no context right after reset. It then builds context three ways: a master ninth clock, an address match, and the set-all sequence. The first-frame window for address matching is hidden as well. The stimulus first closes it with a ninth clock, shows that a match is ignored, and then reopens it with a start. A sweep of all 256 write patterns against an all-ones flag vector covers the read-then-write-0 clearing rule bit by bit.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int NFLAG   = 8;
  localparam int FB_TXE  = 7;
  localparam int FB_TXDN = 6;
  localparam int FB_RXF  = 5;
  localparam int FB_NACK = 4;
  localparam int FB_STOP = 3;
  localparam int FB_LOST = 2;
  localparam int FB_ADDR = 1;
  localparam int FB_GCAL = 0;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/i2c_stat_qual.sv
module i2c_stat_qual
  import i2c_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fmt_sync,
  input  logic      is_master,
  input  logic      is_xmit,
  input  logic      ack_chk_en,
  input  logic      sda_hi,
  input  logic      ev_start_det,
  input  logic      ev_stop_det,
  input  logic      ev_addr_match,
  input  logic      ev_gcall,
  input  logic      ev_sda_mismatch,
  input  logic      ev_nack,
  input  logic      ev_tx_load,
  input  logic      ev_trs_set,
  input  logic      ev_start_gen,
  input  logic      ev_slv_to_tx,
  input  logic      ev_ninth_scl,
  input  logic      ev_tx_last,
  input  logic      ev_rx_last,
  input  logic      ev_rx_xfer,
  input  logic      txd_wr,
  input  logic      rxd_rd,
  input  flag_vec_t cur,
  output flag_vec_t set_v,
  output flag_vec_t hclr_v
);
  logic first_frame;
  logic stop_armed;
  logic slv_rx;
  logic i2c_mode;

  assign slv_rx   = !is_master && !is_xmit;
  assign i2c_mode = !fmt_sync;

  always_comb begin
    set_v          = '0;
    set_v[FB_TXE]  = ev_tx_load | ev_trs_set | ev_start_gen | ev_slv_to_tx;
    set_v[FB_TXDN] = fmt_sync ? ev_tx_last : (ev_ninth_scl & cur[FB_TXE]);
    set_v[FB_RXF]  = ev_rx_xfer;
    set_v[FB_NACK] = ev_nack & ack_chk_en;
    set_v[FB_STOP] = i2c_mode & ev_stop_det & stop_armed;
    set_v[FB_LOST] = fmt_sync ? (ev_rx_last & cur[FB_RXF])
                              : (is_master & ((is_xmit & ev_sda_mismatch) |
                                              (ev_start_det & sda_hi)));
    set_v[FB_ADDR] = i2c_mode & slv_rx & first_frame & ev_addr_match;
    set_v[FB_GCAL] = i2c_mode & slv_rx & first_frame & ev_gcall;
  end

  always_comb begin
    hclr_v          = '0;
    hclr_v[FB_TXE]  = txd_wr;
    hclr_v[FB_TXDN] = txd_wr;
    hclr_v[FB_RXF]  = rxd_rd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_frame <= 1'b0;
      stop_armed  <= 1'b0;
    end else begin
      if (ev_start_det)      first_frame <= 1'b1;
      else if (ev_ninth_scl) first_frame <= 1'b0;
      if (ev_stop_det)
        stop_armed <= 1'b0;
      else if ((is_master & ev_ninth_scl) | set_v[FB_ADDR] | set_v[FB_GCAL])
        stop_armed <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_stat_cell.sv
module i2c_stat_cell (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (hw_set)                    q <= 1'b1;
      else if (hw_clr)               q <= 1'b0;
      else if (wr && !wbit && armed) q <= 1'b0;
      if (rd)      armed <= q;
      else if (wr) armed <= 1'b0;
      else         armed <= armed & q;
    end
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             fmt_sync,
  input  logic             is_master,
  input  logic             is_xmit,
  input  logic             ack_chk_en,
  input  logic             sda_hi,
  input  logic             ev_start_det,
  input  logic             ev_stop_det,
  input  logic             ev_addr_match,
  input  logic             ev_gcall,
  input  logic             ev_sda_mismatch,
  input  logic             ev_nack,
  input  logic             ev_tx_load,
  input  logic             ev_trs_set,
  input  logic             ev_start_gen,
  input  logic             ev_slv_to_tx,
  input  logic             ev_ninth_scl,
  input  logic             ev_tx_last,
  input  logic             ev_rx_last,
  input  logic             ev_rx_xfer,
  input  logic             txd_wr,
  input  logic             rxd_rd,
  input  logic             st_rd,
  input  logic             st_wr,
  input  logic [NFLAG-1:0] st_wdata,
  output logic [NFLAG-1:0] st_rdata,
  output logic [NFLAG-1:0] flags_o
);
  flag_vec_t cur, set_v, hclr_v;

  i2c_stat_qual u_qual (
    .clk(clk), .rst(rst), .fmt_sync(fmt_sync), .is_master(is_master),
    .is_xmit(is_xmit), .ack_chk_en(ack_chk_en), .sda_hi(sda_hi),
    .ev_start_det(ev_start_det), .ev_stop_det(ev_stop_det),
    .ev_addr_match(ev_addr_match), .ev_gcall(ev_gcall),
    .ev_sda_mismatch(ev_sda_mismatch), .ev_nack(ev_nack),
    .ev_tx_load(ev_tx_load), .ev_trs_set(ev_trs_set),
    .ev_start_gen(ev_start_gen), .ev_slv_to_tx(ev_slv_to_tx),
    .ev_ninth_scl(ev_ninth_scl), .ev_tx_last(ev_tx_last),
    .ev_rx_last(ev_rx_last), .ev_rx_xfer(ev_rx_xfer),
    .txd_wr(txd_wr), .rxd_rd(rxd_rd), .cur(cur),
    .set_v(set_v), .hclr_v(hclr_v)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_cell
    i2c_stat_cell u_cell (
      .clk(clk), .rst(rst), .hw_set(set_v[i]), .hw_clr(hclr_v[i]),
      .rd(st_rd), .wr(st_wr), .wbit(st_wdata[i]), .q(cur[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        st_rdata <= '0;
    else if (st_rd) st_rdata <= cur;
  end

  assign flags_o = cur;
endmodule

// File: rtl/i2c_stat_flags_chk.sv
module i2c_stat_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       ack_chk_en,
  input logic       ev_nack,
  input logic       ev_tx_load,
  input logic       ev_trs_set,
  input logic       ev_start_gen,
  input logic       ev_slv_to_tx,
  input logic       ev_rx_xfer,
  input logic       txd_wr,
  input logic [7:0] flags_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> flags_o == 8'h00); // R1

  AST_TXD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    txd_wr && !(ev_tx_load || ev_trs_set || ev_start_gen || ev_slv_to_tx)
    |=> !flags_o[7] && !flags_o[6]); // R5

  AST_RXF_SETS: assert property (@(posedge clk) disable iff (rst)
    ev_rx_xfer |=> flags_o[5]); // R7

  AST_RXF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flags_o[5]) |-> $past(ev_rx_xfer)); // R7

  AST_NACK_GATED: assert property (@(posedge clk) disable iff (rst)
    !flags_o[4] && ev_nack && !ack_chk_en |=> !flags_o[4]); // R8

  AST_TXE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_trs_set |=> flags_o[7]); // R13
endmodule

bind i2c_stat_flags i2c_stat_flags_chk u_chk (.*);

// File: tb/sim_i2c_stat_flags.sv
module sim_i2c_stat_flags;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fmt_sync = 0, is_master = 0, is_xmit = 0, ack_chk_en = 0, sda_hi = 0;
  logic [15:0] ev = '0;
  logic st_rd = 0, st_wr = 0;
  logic [7:0] st_wdata = '0;
  logic [7:0] st_rdata, flags_o;
  int nchk = 0, nerr = 0;
  bit done = 0;

  localparam int E_START = 0, E_STOP = 1, E_ADDR = 2, E_GCAL = 3, E_MISM = 4,
                 E_NACK = 5, E_TXLD = 6, E_TRS = 7, E_SGEN = 8, E_S2T = 9,
                 E_NINE = 10, E_TXLST = 11, E_RXLST = 12, E_RXX = 13,
                 E_TXDW = 14, E_RXDR = 15;

  always #4 clk = ~clk;

  i2c_stat_flags u0 (
    .clk(clk), .rst(rst), .fmt_sync(fmt_sync), .is_master(is_master),
    .is_xmit(is_xmit), .ack_chk_en(ack_chk_en), .sda_hi(sda_hi),
    .ev_start_det(ev[E_START]), .ev_stop_det(ev[E_STOP]),
    .ev_addr_match(ev[E_ADDR]), .ev_gcall(ev[E_GCAL]),
    .ev_sda_mismatch(ev[E_MISM]), .ev_nack(ev[E_NACK]),
    .ev_tx_load(ev[E_TXLD]), .ev_trs_set(ev[E_TRS]),
    .ev_start_gen(ev[E_SGEN]), .ev_slv_to_tx(ev[E_S2T]),
    .ev_ninth_scl(ev[E_NINE]), .ev_tx_last(ev[E_TXLST]),
    .ev_rx_last(ev[E_RXLST]), .ev_rx_xfer(ev[E_RXX]),
    .txd_wr(ev[E_TXDW]), .rxd_rd(ev[E_RXDR]),
    .st_rd(st_rd), .st_wr(st_wr), .st_wdata(st_wdata),
    .st_rdata(st_rdata), .flags_o(flags_o)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [15:0] m);
    @(negedge clk) ev = m;
    @(negedge clk) ev = '0;
  endtask

  task automatic st_read();
    @(negedge clk) st_rd = 1'b1;
    @(negedge clk) st_rd = 1'b0;
  endtask

  task automatic st_write(logic [7:0] v);
    @(negedge clk) begin st_wr = 1'b1; st_wdata = v; end
    @(negedge clk) st_wr = 1'b0;
  endtask

  task automatic clr_all();
    st_read();
    st_write(8'h00);
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    fmt_sync = 0; is_master = 0; is_xmit = 0; ack_chk_en = 0; sda_hi = 0;
  endtask

  task automatic set_all();
    fmt_sync = 0; is_master = 1; is_xmit = 1; ack_chk_en = 1; sda_hi = 0;
    pulse(16'(1) << E_TRS);
    pulse(16'(1) << E_NINE);
    pulse(16'(1) << E_RXX);
    pulse(16'(1) << E_NACK);
    pulse(16'(1) << E_STOP);
    pulse(16'(1) << E_MISM);
    is_master = 0; is_xmit = 0;
    pulse(16'(1) << E_START);
    pulse((16'(1) << E_ADDR) | (16'(1) << E_GCAL));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 flags", flags_o, 8'h00);
    chk("R1 rdata", st_rdata, 8'h00);

    // R12: stop with no context
    is_master = 1;
    pulse(16'(1) << E_STOP);
    chk("R12 no context", flags_o, 8'h00);
    // R6: ninth clock with transmit empty 0
    pulse(16'(1) << E_NINE);
    chk("R6 ninth w/o txe", flags_o, 8'h00);
    pulse(16'(1) << E_STOP);
    chk("R12 after master frame", flags_o, 8'h08);
    st_read();
    chk("R14 rdata", st_rdata, 8'h08);
    st_write(8'h00);
    chk("R2 read then write0", flags_o, 8'h00);

    // R4 / R5
    for (int e = E_TXLD; e <= E_S2T; e++) begin
      pulse(16'(1) << e);
      chk("R4 txe source", flags_o, 8'h80);
      pulse(16'(1) << E_TXDW);
      chk("R5 txd write", flags_o, 8'h00);
    end
    pulse(16'(1) << E_TRS);
    pulse(16'(1) << E_NINE);
    chk("R6 ninth with txe", flags_o, 8'hC0);
    pulse(16'(1) << E_TXDW);
    chk("R5 clears both", flags_o, 8'h00);

    // R3
    pulse(16'(1) << E_TRS);
    st_write(8'h00);
    chk("R3 write0 no read", flags_o, 8'h80);
    st_read();
    st_write(8'h80);
    chk("R3 write1", flags_o, 8'h80);
    st_write(8'h00);
    chk("R3 permission consumed", flags_o, 8'h80);
    st_read();
    chk("R14 hold", st_rdata, 8'h80);
    pulse(16'(1) << E_TRS);
    chk("R14 held until next read", st_rdata, 8'h80);
    st_write(8'h00);
    chk("R2 clear", flags_o, 8'h00);

    // R13
    pulse(16'(1) << E_TRS);
    st_read();
    @(negedge clk) begin st_wr = 1; st_wdata = 8'h00; ev = 16'(1) << E_TRS; end
    @(negedge clk) begin st_wr = 0; ev = '0; end
    chk("R13 set beats write clear", flags_o, 8'h80);
    @(negedge clk) begin ev = (16'(1) << E_TRS) | (16'(1) << E_TXDW); end
    @(negedge clk) ev = '0;
    chk("R13 set beats txd clear", flags_o, 8'h80);
    pulse(16'(1) << E_TXDW);

    // R7
    pulse(16'(1) << E_RXX);
    chk("R7 set", flags_o, 8'h20);
    pulse(16'(1) << E_RXDR);
    chk("R7 clear", flags_o, 8'h00);

    // R8
    ack_chk_en = 0;
    pulse(16'(1) << E_NACK);
    chk("R8 disabled", flags_o, 8'h00);
    ack_chk_en = 1;
    pulse(16'(1) << E_NACK);
    chk("R8 enabled", flags_o, 8'h10);
    clr_all();

    // R9
    is_master = 1; is_xmit = 1;
    pulse(16'(1) << E_MISM);
    chk("R9 master tx mismatch", flags_o, 8'h04);
    clr_all();
    is_master = 0;
    pulse(16'(1) << E_MISM);
    chk("R9 slave mismatch", flags_o, 8'h00);
    is_master = 1; is_xmit = 0;
    pulse(16'(1) << E_MISM);
    chk("R9 master rx mismatch", flags_o, 8'h00);
    sda_hi = 1;
    pulse(16'(1) << E_START);
    chk("R9 start while sda high", flags_o, 8'h04);
    clr_all();
    sda_hi = 0;
    pulse(16'(1) << E_START);
    chk("R9 start sda low", flags_o, 8'h00);

    // R10 and synchronous R6
    fmt_sync = 1; is_master = 0;
    pulse(16'(1) << E_RXLST);
    chk("R10 no overrun", flags_o, 8'h00);
    pulse(16'(1) << E_RXX);
    pulse(16'(1) << E_RXLST);
    chk("R10 overrun", flags_o, 8'h24);
    pulse(16'(1) << E_TXLST);
    chk("R6 sync last bit", flags_o, 8'h64);
    pulse(16'(1) << E_RXDR);
    pulse(16'(1) << E_TXDW);
    chk("R5 R7 hw clears", flags_o, 8'h04);
    clr_all();
    chk("R2 clear overrun", flags_o, 8'h00);
    fmt_sync = 0;

    // R11 / R12
    is_master = 0; is_xmit = 0;
    pulse(16'(1) << E_NINE);
    pulse(16'(1) << E_ADDR);
    chk("R11 outside first frame", flags_o, 8'h00);
    pulse(16'(1) << E_START);
    pulse(16'(1) << E_ADDR);
    chk("R11 address match", flags_o, 8'h02);
    pulse(16'(1) << E_GCAL);
    chk("R11 general call", flags_o, 8'h03);
    pulse(16'(1) << E_STOP);
    chk("R12 stop after match", flags_o, 8'h0B);
    clr_all();
    is_xmit = 1;
    pulse(16'(1) << E_START);
    pulse(16'(1) << E_ADDR);
    chk("R11 slave transmit ignored", flags_o, 8'h00);
    is_xmit = 0;

    // R2 sweep over all write patterns
    for (int p = 0; p < 256; p++) begin
      set_all();
      st_read();
      st_write(8'(p));
      chk("R2 sweep", flags_o, 8'(p));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule